// File: doc/BRIEF.md
# Prioritized interrupt request controller

This block collects interrupt requests for a processor core and decides whether one of them should interrupt the running code. There are three internal sources: a timer group and two DMA channels. Each raises a request with a one-cycle set pulse. There are also four external request lines. Every source has a small control register that holds a 3-bit priority and a mask bit. Each external source also has a trigger-mode bit. The block keeps a request vector and an in-service vector, and drives one aggregated interrupt line toward the CPU.

The CPU side acknowledges a source with a strobe and an 8-bit source mask. That marks the source in service and normally retires its request. An end-of-interrupt strobe with its own mask takes sources back out of service. External lines are watched for changes of level. A line held at the same level does nothing. A line set to level-trigger mode keeps its request through an acknowledge for as long as the line stays high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is active, and after it ends, the request vector, the in-service vector and the recorded external levels are all zero. Every control register reads 0x0F: masked, priority 7. `irq_o` is low.
- R2: Select codes are 0 for timer, 1 for DMA0, 2 for DMA1, and 3 to 6 for external lines 0 to 3. A control write stores `cfg_data_i` ANDed with the kept bits for that register:
  - bits [3:0] for the internal sources;
  - bits [6:0] for external lines 0 and 1;
  - bits [4:0] for external lines 2 and 3.
  
  Select 7 is ignored and reads 0. `cfg_rd_data_o` shows the register picked by `cfg_rd_sel_i` without delay. Field positions: priority [2:0], mask bit 3 (1 = masked), level-trigger bit 4.
- R3: Source bit positions in `req_o`, `isr_o`, `ack_mask_i` and `eoi_mask_i` are: timer bit 0, DMA0 bit 1, DMA1 bit 2, external line n bit 4+n. Bit 3 always reads 0. An external line going from low to high, or a set pulse on `int_set_i[k]`, sets the matching request bit at that clock edge.
- R4: An external line that stays at its recorded level has no effect. A line held high does not set its request again after an acknowledge retired it. A line held low does not clear its in-service bit.
- R5: An external line going from high to low clears both its request bit and its in-service bit.
- R6: An acknowledge ORs `ack_mask_i` into the in-service vector. When the mask has no external bit (bits 7:4 all zero), every masked request bit is cleared.
- R7: When the acknowledge mask holds external bits, the lowest such bit selects a control register. If that register's level-trigger bit is 0, every request bit in the mask is cleared. If it is 1, no request bit is cleared, internal ones included.
- R8: An end-of-interrupt strobe clears the in-service bits named in `eoi_mask_i`.
- R9: `irq_o` is high exactly when some unmasked pending source has a priority value lower than that of every in-service source. An empty in-service vector counts as lower than any priority.
- R10: A control write changes `irq_o` from the clock edge that stores it. Within one edge the updates apply in this order: end of interrupt, acknowledge, external level changes, internal set pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_sel_i | input | 3 | Control register select for writes |
| cfg_data_i | input | 7 | Control write data |
| cfg_rd_sel_i | input | 3 | Control register select for readback |
| cfg_rd_data_o | output | 7 | Readback of the selected control register |
| ext_irq_i | input | 4 | External request lines |
| int_set_i | input | 3 | Internal source set pulses (timer, DMA0, DMA1) |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_mask_i | input | 8 | Sources being acknowledged |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_mask_i | input | 8 | Sources leaving service |
| req_o | output | 8 | Request vector |
| isr_o | output | 8 | In-service vector |
| irq_o | output | 1 | Aggregated interrupt toward the CPU |

## Verification
Every stimulus (line change, set pulse, acknowledge, end of interrupt, control write) is sampled at one rising edge and takes effect there. `req_o`, `isr_o` and `irq_o` are due after that same edge and are never delayed by a further register. The bench drives on falling edges and compares on the next falling edge, one edge after the stimulus. Readback is combinational, so a read is checked a fraction of a cycle after its select changes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // default geometry of the controller
    localparam int IRQC_PRI_W    = 3;
    localparam int IRQC_CTRL_W   = 7;
    localparam int IRQC_N_INT    = 3;
    localparam int IRQC_N_EXT    = 4;
    localparam int IRQC_EXT_BASE = 4;
    localparam int IRQC_MASK_BIT = 3;
    localparam int IRQC_LTM_BIT  = 4;
endpackage

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs #(
    parameter int N_INT      = 3,
    parameter int N_EXT      = 4,
    parameter int N_EXT_WIDE = 2,
    parameter int CTRL_W     = 7,
    parameter int INT_KEEP_W = 4,
    parameter int EXT_KEEP_W = 5,
    parameter int PRI_W      = 3,
    parameter int MASK_BIT   = 3,
    parameter int LTM_BIT    = 4,
    parameter int SEL_W      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [SEL_W-1:0]         wr_sel_i,
    input  logic [CTRL_W-1:0]        wr_data_i,
    input  logic [SEL_W-1:0]         rd_sel_i,
    output logic [CTRL_W-1:0]        rd_data_o,
    output logic [N_INT+N_EXT-1:0]   masked_o,
    output logic [(N_INT+N_EXT)*PRI_W-1:0] pri_o,
    output logic [N_EXT-1:0]         ltm_o
);
    localparam int N_REG = N_INT + N_EXT;
    localparam logic [CTRL_W-1:0] RST_VAL =
        CTRL_W'((1 << MASK_BIT) | ((1 << PRI_W) - 1));

    function automatic logic [CTRL_W-1:0] keep_bits(input int idx);
        int w;
        if (idx < N_INT)                   w = INT_KEEP_W;
        else if (idx < N_INT + N_EXT_WIDE) w = CTRL_W;
        else                               w = EXT_KEEP_W;
        return CTRL_W'((64'd1 << w) - 64'd1);
    endfunction

    typedef struct packed {
        logic [N_REG-1:0][CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_REG; i++) begin
            if (wr_en_i && (wr_sel_i == SEL_W'(i)))
                st_d.ctrl[i] = wr_data_i & keep_bits(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REG; i++) st_q.ctrl[i] <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (rd_sel_i == SEL_W'(i)) rd_data_o = st_q.ctrl[i];
        end
    end

    for (genvar i = 0; i < N_REG; i++) begin : g_fields
        assign pri_o[i*PRI_W +: PRI_W] = st_q.ctrl[i][PRI_W-1:0];
        assign masked_o[i]             = st_q.ctrl[i][MASK_BIT];
    end

    for (genvar n = 0; n < N_EXT; n++) begin : g_ltm
        assign ltm_o[n] = st_q.ctrl[N_INT+n][LTM_BIT];
    end
endmodule

// File: rtl/irqc_req_state.sv
module irqc_req_state #(
    parameter int N_INT    = 3,
    parameter int N_EXT    = 4,
    parameter int EXT_BASE = 4,
    parameter int SRC_W    = EXT_BASE + N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_INT-1:0] int_set_i,
    input  logic             ack_valid_i,
    input  logic [SRC_W-1:0] ack_mask_i,
    input  logic             eoi_valid_i,
    input  logic [SRC_W-1:0] eoi_mask_i,
    input  logic [N_EXT-1:0] ext_ltm_i,
    output logic [SRC_W-1:0] req_o,
    output logic [SRC_W-1:0] isr_o
);
    function automatic logic [SRC_W-1:0] live_bits();
        logic [SRC_W-1:0] v;
        for (int i = 0; i < SRC_W; i++) v[i] = (i < N_INT) || (i >= EXT_BASE);
        return v;
    endfunction
    localparam logic [SRC_W-1:0] LIVE = live_bits();

    typedef struct packed {
        logic [SRC_W-1:0] req;
        logic [SRC_W-1:0] isr;
        logic [N_EXT-1:0] lvl;
    } state_t;

    state_t st_d, st_q;
    logic   may_clear;
    logic   ext_hit;

    always_comb begin
        st_d      = st_q;
        may_clear = 1'b1;
        ext_hit   = 1'b0;
        // end of interrupt first
        if (eoi_valid_i) st_d.isr = st_d.isr & ~eoi_mask_i;
        // acknowledge: lowest external bit decides whether requests retire
        if (ack_valid_i) begin
            st_d.isr = st_d.isr | ack_mask_i;
            for (int n = 0; n < N_EXT; n++) begin
                if (!ext_hit && ack_mask_i[EXT_BASE+n]) begin
                    ext_hit   = 1'b1;
                    may_clear = ~ext_ltm_i[n];
                end
            end
            if (may_clear) st_d.req = st_d.req & ~ack_mask_i;
        end
        // external level changes; repeated levels leave everything alone
        for (int n = 0; n < N_EXT; n++) begin
            if (ext_irq_i[n] != st_q.lvl[n]) begin
                st_d.lvl[n]            = ext_irq_i[n];
                st_d.req[EXT_BASE+n]   = ext_irq_i[n];
                if (!ext_irq_i[n]) st_d.isr[EXT_BASE+n] = 1'b0;
            end
        end
        st_d.req[N_INT-1:0] = st_d.req[N_INT-1:0] | int_set_i;
        st_d.req = st_d.req & LIVE;
        st_d.isr = st_d.isr & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
    assign isr_o = st_q.isr;
endmodule

// File: rtl/irqc_prio_resolve.sv
module irqc_prio_resolve #(
    parameter int N_INT    = 3,
    parameter int N_EXT    = 4,
    parameter int EXT_BASE = 4,
    parameter int PRI_W    = 3,
    parameter int SRC_W    = EXT_BASE + N_EXT
) (
    input  logic [SRC_W-1:0]               req_i,
    input  logic [SRC_W-1:0]               isr_i,
    input  logic [N_INT+N_EXT-1:0]         masked_i,
    input  logic [(N_INT+N_EXT)*PRI_W-1:0] pri_i,
    output logic                           irq_o
);
    logic [SRC_W-1:0][PRI_W-1:0] src_pri;
    logic [SRC_W-1:0]            src_masked;
    logic [PRI_W:0]              floor_pri;

    for (genvar b = 0; b < SRC_W; b++) begin : g_map
        if (b < N_INT) begin : g_int
            assign src_pri[b]    = pri_i[b*PRI_W +: PRI_W];
            assign src_masked[b] = masked_i[b];
        end else if (b >= EXT_BASE) begin : g_ext
            assign src_pri[b]    = pri_i[(b-EXT_BASE+N_INT)*PRI_W +: PRI_W];
            assign src_masked[b] = masked_i[b-EXT_BASE+N_INT];
        end else begin : g_gap
            assign src_pri[b]    = '1;
            assign src_masked[b] = 1'b1;
        end
    end

    always_comb begin
        floor_pri = {1'b1, {PRI_W{1'b0}}};
        for (int b = 0; b < SRC_W; b++) begin
            if (isr_i[b] && ({1'b0, src_pri[b]} < floor_pri))
                floor_pri = {1'b0, src_pri[b]};
        end
        irq_o = 1'b0;
        for (int b = 0; b < SRC_W; b++) begin
            if (req_i[b] && !src_masked[b] && ({1'b0, src_pri[b]} < floor_pri))
                irq_o = 1'b1;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_INT    = IRQC_N_INT,
    parameter int N_EXT    = IRQC_N_EXT,
    parameter int EXT_BASE = IRQC_EXT_BASE,
    parameter int PRI_W    = IRQC_PRI_W,
    parameter int CTRL_W   = IRQC_CTRL_W,
    parameter int SEL_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr_i,
    input  logic [SEL_W-1:0]              cfg_sel_i,
    input  logic [CTRL_W-1:0]             cfg_data_i,
    input  logic [SEL_W-1:0]              cfg_rd_sel_i,
    output logic [CTRL_W-1:0]             cfg_rd_data_o,
    input  logic [N_EXT-1:0]              ext_irq_i,
    input  logic [N_INT-1:0]              int_set_i,
    input  logic                          ack_valid_i,
    input  logic [EXT_BASE+N_EXT-1:0]     ack_mask_i,
    input  logic                          eoi_valid_i,
    input  logic [EXT_BASE+N_EXT-1:0]     eoi_mask_i,
    output logic [EXT_BASE+N_EXT-1:0]     req_o,
    output logic [EXT_BASE+N_EXT-1:0]     isr_o,
    output logic                          irq_o
);
    localparam int N_REG = N_INT + N_EXT;
    localparam int SRC_W = EXT_BASE + N_EXT;

    logic [N_REG-1:0]       masked;
    logic [N_REG*PRI_W-1:0] pri;
    logic [N_EXT-1:0]       ltm;

    irqc_ctrl_regs #(
        .N_INT(N_INT), .N_EXT(N_EXT), .N_EXT_WIDE(2), .CTRL_W(CTRL_W),
        .INT_KEEP_W(4), .EXT_KEEP_W(5), .PRI_W(PRI_W),
        .MASK_BIT(IRQC_MASK_BIT), .LTM_BIT(IRQC_LTM_BIT), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(cfg_wr_i), .wr_sel_i(cfg_sel_i), .wr_data_i(cfg_data_i),
        .rd_sel_i(cfg_rd_sel_i), .rd_data_o(cfg_rd_data_o),
        .masked_o(masked), .pri_o(pri), .ltm_o(ltm)
    );

    irqc_req_state #(
        .N_INT(N_INT), .N_EXT(N_EXT), .EXT_BASE(EXT_BASE), .SRC_W(SRC_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n),
        .ext_irq_i(ext_irq_i), .int_set_i(int_set_i),
        .ack_valid_i(ack_valid_i), .ack_mask_i(ack_mask_i),
        .eoi_valid_i(eoi_valid_i), .eoi_mask_i(eoi_mask_i),
        .ext_ltm_i(ltm), .req_o(req_o), .isr_o(isr_o)
    );

    irqc_prio_resolve #(
        .N_INT(N_INT), .N_EXT(N_EXT), .EXT_BASE(EXT_BASE), .PRI_W(PRI_W), .SRC_W(SRC_W)
    ) u_prio (
        .req_i(req_o), .isr_i(isr_o), .masked_i(masked), .pri_i(pri), .irq_o(irq_o)
    );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_INT    = 3,
    parameter int N_EXT    = 4,
    parameter int EXT_BASE = 4,
    parameter int SRC_W    = EXT_BASE + N_EXT
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_EXT-1:0] ext_irq_i,
    input logic [N_INT-1:0] int_set_i,
    input logic             ack_valid_i,
    input logic [SRC_W-1:0] ack_mask_i,
    input logic             eoi_valid_i,
    input logic [SRC_W-1:0] eoi_mask_i,
    input logic [SRC_W-1:0] req_o,
    input logic [SRC_W-1:0] isr_o,
    input logic             irq_o
);
    localparam logic [SRC_W-1:0] INT_BITS = SRC_W'((1 << N_INT) - 1);

    for (genvar n = 0; n < N_EXT; n++) begin : g_ext
        // R3: a rising line sets its request
        p_ext_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ext_irq_i[n]) |=> req_o[EXT_BASE+n]);
        // R5: a falling line clears request and in-service
        p_ext_fall_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ext_irq_i[n]) |=> (!req_o[EXT_BASE+n] && !isr_o[EXT_BASE+n]));
    end

    // R6: acknowledge of internal sources only retires those requests
    p_int_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && (ack_mask_i[SRC_W-1:EXT_BASE] == '0) &&
         ((SRC_W'(int_set_i) & ack_mask_i) == '0))
        |=> ((req_o & $past(ack_mask_i)) == '0));

    // R6: acknowledge marks internal sources in service
    p_ack_marks_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_i && !eoi_valid_i)
        |=> ((isr_o & $past(ack_mask_i) & INT_BITS) == ($past(ack_mask_i) & INT_BITS)));

    // R8: end of interrupt takes sources out of service
    p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid_i && !ack_valid_i) |=> ((isr_o & $past(eoi_mask_i)) == '0));

    // R9: the CPU line never rises without a pending request
    p_irq_has_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_o != '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_INT(N_INT), .N_EXT(N_EXT), .EXT_BASE(EXT_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .int_set_i(int_set_i),
    .ack_valid_i(ack_valid_i), .ack_mask_i(ack_mask_i),
    .eoi_valid_i(eoi_valid_i), .eoi_mask_i(eoi_mask_i),
    .req_o(req_o), .isr_o(isr_o), .irq_o(irq_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [6:0] cfg_data = '0;
    logic [2:0] rd_sel = '0;
    logic [6:0] rd_data;
    logic [3:0] ext = '0;
    logic [2:0] iset = '0;
    logic       ack_v = 1'b0;
    logic [7:0] ack_m = '0;
    logic       eoi_v = 1'b0;
    logic [7:0] eoi_m = '0;
    logic [7:0] req, isr;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_data_i(cfg_data), .cfg_rd_sel_i(rd_sel), .cfg_rd_data_o(rd_data),
        .ext_irq_i(ext), .int_set_i(iset), .ack_valid_i(ack_v), .ack_mask_i(ack_m),
        .eoi_valid_i(eoi_v), .eoi_mask_i(eoi_m), .req_o(req), .isr_o(isr), .irq_o(irq)
    );

    // reference model built from the requirements
    logic [7:0] m_req, m_isr, t_req, t_isr;
    logic [3:0] m_lvl;
    logic [6:0] m_ctrl [7];
    logic       t_clr;

    function automatic logic [6:0] kept(input int i);
        if (i < 3) return 7'h0F;
        if (i < 5) return 7'h7F;
        if (i < 7) return 7'h1F;
        return 7'h00;
    endfunction

    function automatic int reg_of(input int b);
        return (b < 3) ? b : b - 1;
    endfunction

    function automatic logic model_irq();
        int best = 8;
        for (int b = 0; b < 8; b++)
            if (b != 3 && m_isr[b] && int'(m_ctrl[reg_of(b)][2:0]) < best)
                best = int'(m_ctrl[reg_of(b)][2:0]);
        for (int b = 0; b < 8; b++)
            if (b != 3 && m_req[b] && !m_ctrl[reg_of(b)][3] &&
                int'(m_ctrl[reg_of(b)][2:0]) < best)
                return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req = '0; m_isr = '0; m_lvl = '0;
            for (int i = 0; i < 7; i++) m_ctrl[i] = 7'h0F;
        end else begin
            t_req = m_req; t_isr = m_isr;
            if (eoi_v) t_isr = t_isr & ~eoi_m;
            if (ack_v) begin
                t_isr = t_isr | ack_m;
                t_clr = 1'b1;
                for (int n = 3; n >= 0; n--)
                    if (ack_m[4+n]) t_clr = ~m_ctrl[3+n][4];
                if (t_clr) t_req = t_req & ~ack_m;
            end
            for (int n = 0; n < 4; n++) begin
                if (ext[n] != m_lvl[n]) begin
                    m_lvl[n] = ext[n];
                    t_req[4+n] = ext[n];
                    if (!ext[n]) t_isr[4+n] = 1'b0;
                end
            end
            t_req[2:0] = t_req[2:0] | iset;
            m_req = t_req & 8'hF7;
            m_isr = t_isr & 8'hF7;
            if (cfg_wr && cfg_sel < 7) m_ctrl[cfg_sel] = cfg_data & kept(int'(cfg_sel));
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " req"}, 32'(req), 32'(m_req));
        chk({tag, " isr"}, 32'(isr), 32'(m_isr));
        chk({tag, " irq"}, 32'(irq), 32'(model_irq()));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; ack_v = 1'b0; eoi_v = 1'b0; iset = '0;
    endtask

    task automatic wr(input int sel, input logic [6:0] d);
        cfg_sel = 3'(sel); cfg_data = d; cfg_wr = 1'b1; tick();
    endtask
    task automatic do_ack(input logic [7:0] m); ack_m = m; ack_v = 1'b1; tick(); endtask
    task automatic do_eoi(input logic [7:0] m); eoi_m = m; eoi_v = 1'b1; tick(); endtask
    task automatic do_set(input logic [2:0] s); iset = s; tick(); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        chk("R1 req in reset", 32'(req), 0);
        chk("R1 irq in reset", 32'(irq), 0);
        rst_n = 1'b1;
        tick();
        cmp_all("R1");
        for (int i = 0; i < 7; i++) begin
            rd_sel = 3'(i); #1;
            chk("R1 ctrl reset", 32'(rd_data), 32'h0F);
        end

        // R2: kept bits per register, select 7 ignored
        for (int i = 0; i < 8; i++) begin
            wr(i, 7'h7F);
            rd_sel = 3'(i); #1;
            chk("R2 kept bits", 32'(rd_data), 32'(kept(i)));
        end
        for (int i = 0; i < 7; i++) wr(i, 7'h0F);
        cmp_all("R2 restore");

        // R9: priority sweep timer vs DMA0 with DMA0 in service
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                wr(0, 7'(a)); wr(1, 7'(b));
                do_set(3'b011);
                cmp_all("R3 internal set");
                chk("R9 both pending", 32'(irq), 1);
                do_ack(8'h02);
                cmp_all("R6 ack dma0");
                chk("R9 prio vs isr", 32'(irq), 32'(a < b));
                do_eoi(8'h02);
                do_ack(8'h01);
                do_eoi(8'h01);
                cmp_all("R8 eoi");
                chk("R8 isr empty", 32'(isr), 0);
            end
        end

        // R9/R10: mask bit and write re-evaluation
        wr(0, 7'h0F); wr(1, 7'h0F);
        do_set(3'b001);
        chk("R9 masked source", 32'(irq), 0);
        wr(0, 7'h05);
        chk("R10 unmask write", 32'(irq), 1);
        wr(0, 7'h0D);
        chk("R10 remask write", 32'(irq), 0);
        do_ack(8'h01); do_eoi(8'h01);
        wr(0, 7'h0F);

        // R3..R7: each external line in both trigger modes
        for (int n = 0; n < 4; n++) begin
            for (int l = 0; l < 2; l++) begin
                wr(3 + n, l ? 7'h12 : 7'h02);
                ext[n] = 1'b1; tick();
                cmp_all("R3 rise");
                chk("R3 rise bit", 32'(req[4+n]), 1);
                do_ack(8'(1 << (4 + n)));
                cmp_all("R7 ack ext");
                chk("R7 ltm decides", 32'(req[4+n]), 32'(l));
                chk("R6 isr marked", 32'(isr[4+n]), 1);
                tick(); tick();
                chk("R4 held high", 32'(req[4+n]), 32'(l));
                cmp_all("R4 held high");
                ext[n] = 1'b0; tick();
                cmp_all("R5 fall");
                chk("R5 fall isr", 32'(isr[4+n]), 0);
                do_ack(8'(1 << (4 + n)));
                tick();
                chk("R4 held low isr", 32'(isr[4+n]), 1);
                do_eoi(8'hFF);
                cmp_all("R8 eoi ext");
                wr(3 + n, 7'h0F);
            end
        end

        // R7: lowest external bit decides for the whole mask
        wr(3, 7'h12); wr(4, 7'h03);
        ext = 4'b0011; tick();
        do_ack(8'h30);
        chk("R7 low ext ltm keeps both", 32'(req[5:4]), 32'h3);
        cmp_all("R7 multi");
        do_eoi(8'h30);
        wr(3, 7'h02); wr(4, 7'h13);
        do_ack(8'h30);
        chk("R7 low ext edge clears both", 32'(req[5:4]), 0);
        cmp_all("R7 multi edge");
        ext = 4'b0000; tick();
        do_eoi(8'hFF);

        // R7: mixed internal and external acknowledge
        wr(3, 7'h12);
        ext = 4'b0001; tick();
        do_set(3'b001);
        do_ack(8'h11);
        chk("R7 mixed keeps timer", 32'(req[0]), 1);
        chk("R7 mixed keeps ext", 32'(req[4]), 1);
        do_ack(8'h01);
        chk("R6 timer alone clears", 32'(req[0]), 0);
        cmp_all("R6 mixed");

        // R3: bit 3 never set
        do_ack(8'h08);
        chk("R3 gap bit isr", 32'(isr[3]), 0);
        ext = 4'b0000; tick();
        do_eoi(8'hFF);
        cmp_all("R8 final");

        finish_run();
    end
endmodule